// File: doc/BRIEF.md
# Hybrid Scaling-Free CORDIC Rotator

This block rotates a fixed-point vector (x, y) by a signed angle that lies strictly inside plus or minus a quarter turn. It is a rotation-only CORDIC pipeline with three arithmetic steps. The first step picks one of eight equal sectors and turns the vector by that sector's centre angle, using constant products. This leaves a small residual angle. The second step applies two scaling-free micro-rotations, selected by the top bits of the residual's magnitude. The third step applies four more micro-rotations and then a first-order tail covering the finest residual bits. Every micro-rotation keeps the vector length, so the output is used directly and no gain compensation follows.

A sample is offered with a one-cycle `in_valid` pulse, and a new sample may be offered on every cycle. The rotated vector and the angle left unapplied appear together, qualified by `out_valid`, a fixed number of cycles later. The block suits mixers, phase correctors and coordinate converters that need a steady stream of rotations with constant latency.

Top module: `sf_cordic_rotator`

## Requirements
- R1: The input angle is 18-bit two's complement in radians with 15 fraction bits, and accepted values have magnitude at most 51471 (π/2 is 51472 in this format). The vector inputs and outputs are 16-bit two's complement with 14 fraction bits.
- R2: For input vectors with each component of magnitude at most 0.7, each output component lies within 2 LSB of x·cosθ − y·sinθ and x·sinθ + y·cosθ respectively.
- R3: The sector index is the number of boundaries k·12868 (k = −3 … 3) that are less than or equal to the angle. The sector centre is (2·index − 7)·6434. The residual after the coarse step is the angle minus that centre, and its magnitude never exceeds 6434.
- R4: The two-micro-rotation step uses the 2^-3 and 2^-4 bits of the residual magnitude, with the residual's sign as direction, and hands on a residual of magnitude below 2048.
- R5: The final step uses the bits 2^-5 to 2^-14 of the residual magnitude. With the default finest step of 2^-14, `out_res` equals sign(r)·(|r| mod 2), where r is the residual defined in R3.
- R6: Angles of ±51471, and angles placed exactly on or one LSB beside a sector boundary, meet the R2 accuracy with no gain correction stage.
- R7: `out_valid` rises exactly four clock edges after the edge that samples `in_valid` high. Back-to-back samples come out back-to-back and in order, and `out_valid` is never raised for a cycle in which no sample was offered.
- R8: A synchronous active-low reset drives `out_valid`, `out_x`, `out_y` and `out_res` to zero and discards every sample still in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies one input sample in this cycle |
| in_x | input | 16 | Input x component |
| in_y | input | 16 | Input y component |
| in_angle | input | 18 | Rotation angle in radians |
| out_valid | output | 1 | Qualifies the result in this cycle |
| out_x | output | 16 | Rotated x component |
| out_y | output | 16 | Rotated y component |
| out_res | output | 18 | Angle left unapplied after the finest micro-rotation |

## Verification
The hardest situation to reach from the ports is a residual that sits right at a sector edge, where the sign flips and the magnitude is at its extreme. A random angle lands there rarely. Directed samples are therefore placed exactly on the boundaries and one LSB on either side of them, at ±51471, and at offsets that set both high residual bits. These run back-to-back, and their unapplied-angle output is predicted exactly from the sector arithmetic. A reset issued while samples are still inside the pipeline is directed as well, because uniform random stimulus never produces it.

// File: rtl/sf_cordic_pkg.sv
// Shared widths, lane types and constant helpers for the scaling-free rotator.
// Assumes: angles in radians with AF fraction bits, vectors with XW bits.
package sf_cordic_pkg;

    localparam int XW          = 16;              // vector port width
    localparam int AW          = 18;              // angle width
    localparam int AF          = 15;              // angle fraction bits
    localparam int GUARD       = 6;               // extra internal fraction bits
    localparam int IW          = XW + GUARD + 1;  // internal width with headroom
    localparam int CF          = 18;              // coefficient fraction bits
    localparam int CW          = CF + 1;          // coefficient width
    localparam int SECTOR_STEP = 12868;           // pi/8 in angle LSB

    typedef logic signed [IW-1:0] wide_t;
    typedef logic signed [AW-1:0] ang_t;
    typedef logic signed [CW-1:0] coef_t;

    typedef struct packed {
        wide_t x;
        wide_t y;
        ang_t  r;
    } lane_t;

    typedef struct packed {
        wide_t x;
        wide_t y;
    } pair_t;

    // Centre of sector idx: odd multiples of pi/16.
    function automatic ang_t sector_centre(input logic [2:0] idx);
        return ang_t'((2 * int'(idx) - 7) * (SECTOR_STEP / 2));
    endfunction

    // Cosine of the e-th positive sector centre, CF fraction bits.
    function automatic coef_t centre_cos(input logic [1:0] e);
        case (e)
            2'd0:    return coef_t'(257107);
            2'd1:    return coef_t'(217965);
            2'd2:    return coef_t'(145639);
            default: return coef_t'(51142);
        endcase
    endfunction

    // One scaling-free micro-rotation by +/-2^-k: second-order cosine, third-order sine,
    // with 1/6 taken as 1/8 + 1/32.
    function automatic pair_t sf_micro(input wide_t x, input wide_t y, input logic neg, input int k);
        wide_t cxv, cyv, sxv, syv;
        pair_t o;
        cxv = x - (x >>> (2 * k + 1));
        cyv = y - (y >>> (2 * k + 1));
        sxv = (x >>> k) - ((x >>> (3 * k + 3)) + (x >>> (3 * k + 5)));
        syv = (y >>> k) - ((y >>> (3 * k + 3)) + (y >>> (3 * k + 5)));
        o.x = neg ? (cxv + syv) : (cxv - syv);
        o.y = neg ? (cyv - sxv) : (cyv + sxv);
        return o;
    endfunction

endpackage

// File: rtl/sf_coarse_fold.sv
// Coarse sector step: picks one of eight pi/8 sectors by comparison against fixed
// boundaries, rotates the vector by the sector centre with constant products and
// registers the vector and the residual angle.
// Assumes: |in_ang| < 4*STEP, vector magnitude below 2 so nothing overflows.
module sf_coarse_fold
    import sf_cordic_pkg::*;
#(
    parameter int STEP = SECTOR_STEP
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_vld,
    input  wide_t in_x,
    input  wide_t in_y,
    input  ang_t  in_ang,
    output logic  out_vld,
    output lane_t out_lane
);

    localparam int NBND = 7;
    localparam int HALF = STEP / 2;

    logic [NBND-1:0] above;
    logic [2:0]      idx;
    logic [1:0]      ent;
    logic            neg;
    coef_t           cosv, sinv;
    logic signed [IW+CW-1:0] p_xc, p_ys, p_xs, p_yc, sum_x, sum_y;
    lane_t           nxt;

    // One comparator per sector boundary.
    for (genvar j = 0; j < NBND; j++) begin : g_bnd
        localparam int BND = (j - 3) * STEP;
        assign above[j] = (in_ang >= ang_t'(BND));
    end

    // Sector index is the count of boundaries at or below the angle.
    always_comb begin
        idx = '0;
        for (int j = 0; j < NBND; j++) idx = idx + {2'b00, above[j]};
    end

    assign neg  = ~idx[2];
    assign ent  = idx[2] ? idx[1:0] : ~idx[1:0];
    assign cosv = centre_cos(ent);
    assign sinv = neg ? -centre_cos(~ent) : centre_cos(~ent);

    assign p_xc  = in_x * cosv;
    assign p_ys  = in_y * sinv;
    assign p_xs  = in_x * sinv;
    assign p_yc  = in_y * cosv;
    assign sum_x = p_xc - p_ys;
    assign sum_y = p_xs + p_yc;

    // Combine rotated vector and residual angle into the next lane.
    always_comb begin
        nxt.x = wide_t'(sum_x >>> CF);
        nxt.y = wide_t'(sum_y >>> CF);
        nxt.r = in_ang - sector_centre(idx);
    end

    // Pipeline register of the coarse step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_lane <= '0;
        end else begin
            out_vld  <= in_vld;
            out_lane <= nxt;
        end
    end

    AST_FOLD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($signed(out_lane.r) <= HALF && $signed(out_lane.r) >= -HALF)); // R3

endmodule

// File: rtl/sf_group_stage.sv
// Grouped scaling-free step: all micro-rotation directions come at once from the
// sign and magnitude bits of the incoming residual. N_ROT full micro-rotations
// (k = K_FIRST ...) run in a combinational chain, and an optional first-order tail
// adds bits down to 2^-TAIL_LAST in parallel. The result is registered.
// Assumes: incoming residual magnitude below 2^-(K_FIRST-1), K_FIRST >= 3.
module sf_group_stage
    import sf_cordic_pkg::*;
#(
    parameter int K_FIRST   = 3,
    parameter int N_ROT     = 2,
    parameter int TAIL_LAST = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_vld,
    input  lane_t in_lane,
    output logic  out_vld,
    output lane_t out_lane
);

    localparam int K_TAIL0   = K_FIRST + N_ROT;
    localparam int K_LAST    = (TAIL_LAST > 0) ? TAIL_LAST : K_TAIL0 - 1;
    localparam int N_TAIL    = (TAIL_LAST > 0) ? TAIL_LAST - K_TAIL0 + 1 : 0;
    localparam int KEEP      = AF - K_LAST;
    localparam int ENTRY_LIM = 1 << (AF - K_FIRST + 1);
    localparam int EXIT_LIM  = 1 << KEEP;

    logic            neg;
    logic [AW-1:0]   mag;
    logic [AW-1:0]   kept;
    wide_t           cx [N_ROT+1];
    wide_t           cy [N_ROT+1];
    wide_t           nx, ny;
    lane_t           nxt;

    assign neg   = in_lane.r[AW-1];
    assign mag   = neg ? AW'(-in_lane.r) : AW'(in_lane.r);
    assign kept  = mag & AW'(EXIT_LIM - 1);
    assign cx[0] = in_lane.x;
    assign cy[0] = in_lane.y;

    // Chain of full micro-rotations, each enabled by one magnitude bit.
    for (genvar g = 0; g < N_ROT; g++) begin : g_rot
        localparam int K = K_FIRST + g;
        pair_t rot;
        assign rot       = sf_micro(cx[g], cy[g], neg, K);
        assign cx[g + 1] = mag[AF-K] ? rot.x : cx[g];
        assign cy[g + 1] = mag[AF-K] ? rot.y : cy[g];
    end

    if (N_TAIL > 0) begin : g_tail
        wide_t ax [N_TAIL+1];
        wide_t ay [N_TAIL+1];
        assign ax[0] = '0;
        assign ay[0] = '0;
        // First-order terms: cosine is 1 below the guard bits, so they add in parallel.
        for (genvar t = 0; t < N_TAIL; t++) begin : g_term
            localparam int K = K_TAIL0 + t;
            assign ax[t + 1] = ax[t] + (mag[AF-K] ? (cy[N_ROT] >>> K) : wide_t'(0));
            assign ay[t + 1] = ay[t] + (mag[AF-K] ? (cx[N_ROT] >>> K) : wide_t'(0));
        end
        assign nx = neg ? (cx[N_ROT] + ax[N_TAIL]) : (cx[N_ROT] - ax[N_TAIL]);
        assign ny = neg ? (cy[N_ROT] - ay[N_TAIL]) : (cy[N_ROT] + ay[N_TAIL]);
    end else begin : g_no_tail
        assign nx = cx[N_ROT];
        assign ny = cy[N_ROT];
    end

    // Assemble the lane leaving this step with the unapplied residual.
    always_comb begin
        nxt.x = nx;
        nxt.y = ny;
        nxt.r = neg ? ang_t'(-kept) : ang_t'(kept);
    end

    // Pipeline register of the grouped step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_lane <= '0;
        end else begin
            out_vld  <= in_vld;
            out_lane <= nxt;
        end
    end

    AST_STAGE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> (int'(mag) < ENTRY_LIM)); // R4

    AST_STAGE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($signed(out_lane.r) < EXIT_LIM && $signed(out_lane.r) > -EXIT_LIM)); // R5

endmodule

// File: rtl/sf_cordic_rotator.sv
// Top of the hybrid scaling-free rotator: input register, coarse sector step,
// two-rotation grouped step, four-rotation grouped step with first-order tail, and
// round-to-nearest back to the port width. Latency is four clock edges.
// Assumes: |in_angle| < pi/2, input components small enough that the rotated
// vector fits the output format.
module sf_cordic_rotator
    import sf_cordic_pkg::*;
#(
    parameter int LAST_K = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] in_x,
    input  logic signed [XW-1:0] in_y,
    input  logic signed [AW-1:0] in_angle,
    output logic                 out_valid,
    output logic signed [XW-1:0] out_x,
    output logic signed [XW-1:0] out_y,
    output logic signed [AW-1:0] out_res
);

    localparam int ANG_LIM = 4 * SECTOR_STEP;
    localparam int LAT     = 4;

    logic  r0_vld, f_vld, s2_vld, s3_vld;
    wide_t r0_x, r0_y;
    ang_t  r0_ang;
    lane_t f_lane, s2_lane, s3_lane;
    wide_t rnd_x, rnd_y;
    logic [2:0] since_rst;

    // Input register: widen vectors with headroom and guard bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r0_vld <= 1'b0;
            r0_x   <= '0;
            r0_y   <= '0;
            r0_ang <= '0;
        end else begin
            r0_vld <= in_valid;
            r0_x   <= {in_x[XW-1], in_x, {GUARD{1'b0}}};
            r0_y   <= {in_y[XW-1], in_y, {GUARD{1'b0}}};
            r0_ang <= in_angle;
        end
    end

    sf_coarse_fold #(.STEP(SECTOR_STEP)) i_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (r0_vld),
        .in_x    (r0_x),
        .in_y    (r0_y),
        .in_ang  (r0_ang),
        .out_vld (f_vld),
        .out_lane(f_lane)
    );

    sf_group_stage #(.K_FIRST(3), .N_ROT(2), .TAIL_LAST(0)) i_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (f_vld),
        .in_lane (f_lane),
        .out_vld (s2_vld),
        .out_lane(s2_lane)
    );

    sf_group_stage #(.K_FIRST(5), .N_ROT(4), .TAIL_LAST(LAST_K)) i_quad (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s2_vld),
        .in_lane (s2_lane),
        .out_vld (s3_vld),
        .out_lane(s3_lane)
    );

    // Round half up from the internal width to the port width.
    assign rnd_x     = s3_lane.x + wide_t'(1 << (GUARD - 1));
    assign rnd_y     = s3_lane.y + wide_t'(1 << (GUARD - 1));
    assign out_x     = rnd_x[GUARD +: XW];
    assign out_y     = rnd_y[GUARD +: XW];
    assign out_res   = s3_lane.r;
    assign out_valid = s3_vld;

    // Cycles since reset release, saturating at the latency, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst < LAT) since_rst <= since_rst + 3'd1;
    end

    AST_ANGLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ($signed(in_angle) < ANG_LIM && $signed(in_angle) > -ANG_LIM)); // R1

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, 4))); // R7

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid); // R8

endmodule

// File: tb/test_sf_cordic_rotator.sv
module test_sf_cordic_rotator;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_x = '0;
    logic signed [15:0] in_y = '0;
    logic signed [17:0] in_angle = '0;
    logic               out_valid;
    logic signed [15:0] out_x, out_y;
    logic signed [17:0] out_res;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int    q_x [32];
    int    q_y [32];
    int    q_a [32];
    int    q_due [32];
    string q_tag [32];
    int    rd = 0, wr = 0, nq = 0;

    sf_cordic_rotator i_sf_cordic_rotator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_x(in_x), .in_y(in_y), .in_angle(in_angle),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_res(out_res)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected rotated x from R2 in real arithmetic.
    function automatic int exp_x(int x, int y, int a);
        real th = real'(a) / 32768.0;
        return int'((real'(x) * $cos(th) - real'(y) * $sin(th)));
    endfunction

    function automatic int exp_y(int x, int y, int a);
        real th = real'(a) / 32768.0;
        return int'((real'(x) * $sin(th) + real'(y) * $cos(th)));
    endfunction

    // Expected unapplied angle from the sector rule (R3) and finest step (R5).
    function automatic int exp_res(int a);
        int idx = 0;
        int r, m;
        for (int k = -3; k <= 3; k++) if (a >= k * 12868) idx++;
        r = a - (2 * idx - 7) * 6434;
        m = (r < 0 ? -r : r) % 2;
        return (r < 0) ? -m : m;
    endfunction

    function automatic int absd(int v);
        return v < 0 ? -v : v;
    endfunction

    task automatic check_out();
        int ex, ey, er;
        if (nq > 0 && cyc == q_due[rd]) begin
            checks++;
            if (!out_valid) begin
                fails++;
                $display("FAIL R7 latency: out_valid=%0d expected 1 at cycle %0d", out_valid, cyc);
            end else begin
                ex = exp_x(q_x[rd], q_y[rd], q_a[rd]);
                ey = exp_y(q_x[rd], q_y[rd], q_a[rd]);
                er = exp_res(q_a[rd]);
                checks++;
                if (absd(int'(out_x) - ex) > 2) begin
                    fails++;
                    $display("FAIL %s x angle=%0d: got %0d expected %0d", q_tag[rd], q_a[rd], out_x, ex);
                end
                checks++;
                if (absd(int'(out_y) - ey) > 2) begin
                    fails++;
                    $display("FAIL %s y angle=%0d: got %0d expected %0d", q_tag[rd], q_a[rd], out_y, ey);
                end
                checks++;
                if (int'(out_res) != er) begin
                    fails++;
                    $display("FAIL R5 residual angle=%0d: got %0d expected %0d", q_a[rd], out_res, er);
                end
            end
            rd = (rd + 1) % 32;
            nq--;
        end else if (out_valid) begin
            checks++;
            fails++;
            $display("FAIL R7 spurious out_valid: got 1 expected 0 at cycle %0d", cyc);
        end
    endtask

    task automatic send(bit v, int x, int y, int a, string tag);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_x     = 16'(x);
        in_y     = 16'(y);
        in_angle = 18'(a);
        if (v) begin
            q_x[wr] = x; q_y[wr] = y; q_a[wr] = a;
            q_due[wr] = cyc + 4; q_tag[wr] = tag;
            wr = (wr + 1) % 32;
            nq++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(0, 0, 0, 0, "");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        summary();
    end

    initial begin
        int rx, ry, ra;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R8: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_x !== 16'sd0 || out_y !== 16'sd0 || out_res !== 18'sd0) begin
            fails++;
            $display("FAIL R8 reset state: got v=%0d x=%0d y=%0d r=%0d expected all 0",
                     out_valid, out_x, out_y, out_res);
        end
        rst_n = 1'b1;
        idle(2);

        // R2: plain rotations
        send(1, 8192, 0, 0, "R2");
        send(1, 0, 8192, 25736, "R2");
        send(1, 11000, -5000, -20000, "R2");
        // R6 and R1: extremes of the open range
        send(1, 11468, 0, 51471, "R6");
        send(1, 11468, 11468, -51471, "R6");
        send(1, -9000, 7000, 51471, "R1");
        // R3 and R6: on and beside sector boundaries
        send(1, 10000, 3000, 12868, "R3");
        send(1, 10000, 3000, 12867, "R3");
        send(1, -7000, 9000, -12868, "R3");
        send(1, -7000, 9000, -12869, "R3");
        send(1, 6000, -11000, 38604, "R6");
        send(1, 6000, -11000, -38605, "R6");
        send(1, 9999, 1111, 0, "R3");
        send(1, 9999, 1111, -1, "R3");
        // R4: residual with both high micro-rotation bits set
        send(1, 11468, -2000, 19302 + 6144, "R4");
        send(1, -3000, 11468, -32170 - 6144, "R4");
        // R5: odd residuals of either sign
        send(1, 8000, 4000, 6435, "R5");
        send(1, 8000, 4000, 6433, "R5");
        idle(6);

        // R7 and R2: random stream, mostly back-to-back
        for (int i = 0; i < 400; i++) begin
            rx = int'($urandom_range(22936)) - 11468;
            ry = int'($urandom_range(22936)) - 11468;
            ra = int'($urandom_range(102942)) - 51471;
            if ($urandom_range(7) == 0) send(0, 0, 0, 0, "");
            else send(1, rx, ry, ra, "R2");
        end
        idle(6);

        // R8: reset with samples in flight discards them
        send(1, 5000, 5000, 1000, "R8");
        send(1, 5000, 5000, 2000, "R8");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        nq = 0; rd = 0; wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid) begin
                fails++;
                $display("FAIL R8 flushed sample emerged: got out_valid=1 expected 0");
            end
        end

        // R7: recovery after reset
        send(1, 7000, -7000, 40000, "R7");
        send(1, -7000, 7000, -40000, "R7");
        idle(6);
        summary();
    end

endmodule